// File: doc/BRIEF.md
# Parallel Port Reverse-Channel Byte Transmitter

This block is the peripheral side of the reverse (peripheral-to-host) channel of an extended-capability parallel port. Local logic hands it one byte plus a flag that marks the byte as data or as a command. The block holds that byte until the host lowers its reverse-request line. It then grants the bus, drives the byte and a data/command tag, and runs the interlocked strobe / host-acknowledge exchange. At the end it returns every line to its resting level in a fixed order.

The host-side inputs are asynchronous and pass through a synchronizer of `SYNC_STAGES` flops before the sequencer sees them. If the host raises reverse request again while the block waits on host acknowledge, the block drops the cycle, releases the bus and keeps the byte, which it sends again at the next grant. Only a cycle that finishes normally gives the one-clock `sent` pulse and frees the local input.

Top module: `pp_rev_tx`

## Requirements
- R1: After reset `bus_oe`=0, `strobe`=1, `tag`=0, `grant_n`=1, `sent`=0 and `in_ready`=1. `in_ready` is high only while no byte is held; a byte is taken on a clock edge with `in_valid`=1 and `in_ready`=1.
- R2: While the synchronized `rev_req_n` is 1, a held byte stays pending: `grant_n` stays 1, `bus_oe` stays 0 and `in_ready` stays 0.
- R3: Once `rev_req_n` is low, `grant_n` falls first, and `bus_oe` rises exactly one clock after `grant_n` falls.
- R4: While `strobe` is low, `bus_dout` equals the held byte and `tag` is 1 for a data byte (`in_is_cmd`=0) and 0 for a command byte (`in_is_cmd`=1). Both are stable for the whole low phase.
- R5: `strobe` falls exactly one clock after `bus_oe` rises.
- R6: `strobe` stays low until the synchronized `host_ack` is 1. It rises on the third clock edge after `host_ack` rises (two synchronizer flops, then the sequencer).
- R7: After `strobe` rises, the block holds the bus (`bus_oe`=1, `sent`=0) until the synchronized `host_ack` is 0.
- R8: On release, `bus_oe` and `tag` fall together on the third clock edge after `host_ack` falls, with `strobe` high. `grant_n` rises exactly one clock later.
- R9: A normal completion gives exactly one `sent` pulse, one clock wide, in the cycle `grant_n` rises. `in_ready` returns to 1 in that same cycle. A stray `in_valid` during the cycle starts no extra transfer.
- R10: If `rev_req_n` rises while the block waits on `host_ack` (with `strobe` low or high), the release sequence of R8 runs with no `sent` pulse and `in_ready` kept at 0. The same byte and tag are sent again after the next grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Local byte offered |
| in_ready | output | 1 | Block is idle and takes a byte |
| in_byte | input | W | Byte to send |
| in_is_cmd | input | 1 | 1 marks a command byte, 0 a data byte |
| sent | output | 1 | One-clock pulse on normal completion |
| host_ack | input | 1 | Host acknowledge, asynchronous |
| rev_req_n | input | 1 | Host reverse request, active low, asynchronous |
| bus_dout | output | W | Value for the bidirectional data lines |
| bus_oe | output | 1 | Output enable for the data lines |
| strobe | output | 1 | Peripheral clock; low marks valid data |
| tag | output | 1 | Peripheral acknowledge: 1 data, 0 command |
| grant_n | output | 1 | Acknowledge of the reverse request, active low |

## Verification
The main exchange is swept over all 256 byte values. Each byte gets a data/command tag taken from its own bits, and the host waits between zero and two extra clocks before each acknowledge edge. This separates a byte or tag mix-up from a timing fault, and proves the exact edge-to-edge latencies for every spacing. Separate patterns hold reverse request high with a byte pending, which shows that the block waits. They also raise reverse request during the strobe-low wait and during the wait for host acknowledge to drop, which shows that a cancel leaves the byte in place and resends it unchanged. A stray offer during a busy cycle shows that the input is gated.

// File: rtl/pp_rev_tx_pkg.sv
package pp_rev_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_ACKED,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_REL
  } rtx_state_e;
endpackage

// File: rtl/pp_rev_sync.sv
module pp_rev_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pp_rev_hold.sv
module pp_rev_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] byte_i,
  input  logic         cmd_i,
  output logic [W-1:0] byte_q,
  output logic         cmd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      cmd_q  <= 1'b0;
    end else if (load) begin
      byte_q <= byte_i;
      cmd_q  <= cmd_i;
    end
  end
endmodule

// File: rtl/pp_rev_fsm.sv
module pp_rev_fsm
  import pp_rev_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic held_cmd,
  input  logic hack_s,
  input  logic req_n_s,
  output logic ready,
  output logic load,
  output logic sent,
  output logic oe,
  output logic strobe,
  output logic tag,
  output logic grant_n
);
  rtx_state_e state;
  logic       cancelled;

  assign load = in_valid & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ready     <= 1'b1;
      sent      <= 1'b0;
      oe        <= 1'b0;
      strobe    <= 1'b1;
      tag       <= 1'b0;
      grant_n   <= 1'b1;
      cancelled <= 1'b0;
    end else begin
      sent <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            ready <= 1'b0;
            state <= ST_PEND;
          end
        end
        ST_PEND: begin
          if (!req_n_s) begin
            grant_n <= 1'b0;
            state   <= ST_ACKED;
          end
        end
        ST_ACKED: begin
          oe    <= 1'b1;
          tag   <= ~held_cmd;
          state <= ST_SETUP;
        end
        ST_SETUP: begin
          strobe <= 1'b0;
          state  <= ST_STROBE;
        end
        ST_STROBE: begin
          if (req_n_s) begin
            cancelled <= 1'b1;
            oe        <= 1'b0;
            tag       <= 1'b0;
            strobe    <= 1'b1;
            state     <= ST_REL;
          end else if (hack_s) begin
            strobe <= 1'b1;
            state  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (req_n_s || !hack_s) begin
            cancelled <= req_n_s;
            oe        <= 1'b0;
            tag       <= 1'b0;
            state     <= ST_REL;
          end
        end
        ST_REL: begin
          grant_n <= 1'b1;
          if (cancelled) begin
            state <= ST_PEND;
          end else begin
            sent  <= 1'b1;
            ready <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_rev_tx.sv
module pp_rev_tx #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_byte,
  input  logic         in_is_cmd,
  output logic         sent,
  input  logic         host_ack,
  input  logic         rev_req_n,
  output logic [W-1:0] bus_dout,
  output logic         bus_oe,
  output logic         strobe,
  output logic         tag,
  output logic         grant_n
);
  logic hack_s, req_n_s, load, held_cmd;

  pp_rev_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_ack (
    .clk(clk), .rst(rst), .d(host_ack), .q(hack_s));

  pp_rev_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_req (
    .clk(clk), .rst(rst), .d(rev_req_n), .q(req_n_s));

  pp_rev_hold #(.W(W)) u_hold (
    .clk(clk), .rst(rst), .load(load), .byte_i(in_byte), .cmd_i(in_is_cmd),
    .byte_q(bus_dout), .cmd_q(held_cmd));

  pp_rev_fsm u_fsm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .held_cmd(held_cmd),
    .hack_s(hack_s), .req_n_s(req_n_s), .ready(in_ready), .load(load),
    .sent(sent), .oe(bus_oe), .strobe(strobe), .tag(tag), .grant_n(grant_n));
endmodule

// File: rtl/pp_rev_tx_chk.sv
module pp_rev_tx_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_ready,
  input logic         sent,
  input logic         bus_oe,
  input logic         strobe,
  input logic         tag,
  input logic         grant_n,
  input logic [W-1:0] bus_dout,
  input logic         hack_s
);
  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (grant_n && !bus_oe && strobe));

  a_r3_grant_before_drive: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> (!grant_n && $past(!grant_n)));

  a_r4_lines_stable: assert property (@(posedge clk) disable iff (rst)
    (!strobe && $past(!strobe)) |-> ($stable(bus_dout) && $stable(tag)));

  a_r5_setup_before_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe) |-> (bus_oe && $past(bus_oe)));

  a_r6_strobe_rise_needs_ack: assert property (@(posedge clk) disable iff (rst)
    ($rose(strobe) && bus_oe) |-> $past(hack_s));

  a_r8_release_order: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_n) |-> (!bus_oe && !tag && strobe && $past(!bus_oe)));

  a_r9_sent_single: assert property (@(posedge clk) disable iff (rst)
    sent |=> !sent);
endmodule

bind pp_rev_tx pp_rev_tx_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .sent(sent), .bus_oe(bus_oe),
  .strobe(strobe), .tag(tag), .grant_n(grant_n), .bus_dout(bus_dout),
  .hack_s(hack_s));

// File: tb/pp_rev_tx_test.sv
module pp_rev_tx_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_is_cmd = 1'b0, host_ack = 1'b0, rev_req_n = 1'b1;
  logic [W-1:0] in_byte = '0;
  logic in_ready, sent, bus_oe, strobe, tag, grant_n;
  logic [W-1:0] bus_dout;

  int n_run = 0, n_fail = 0, cyc = 0;
  int t_gfall = 0, t_oerise = 0, t_sfall = 0;
  logic p_grant = 1'b1, p_oe = 1'b0, p_strobe = 1'b1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pp_rev_tx #(.W(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_cmd(in_is_cmd), .sent(sent),
    .host_ack(host_ack), .rev_req_n(rev_req_n), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .strobe(strobe), .tag(tag), .grant_n(grant_n));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (p_grant && !grant_n) t_gfall  <= cyc;
    if (!p_oe && bus_oe)     t_oerise <= cyc;
    if (p_strobe && !strobe) t_sfall  <= cyc;
    p_grant <= grant_n; p_oe <= bus_oe; p_strobe <= strobe;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic offer(input logic [W-1:0] b, input logic c);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_is_cmd = c;
    @(negedge clk);
    in_valid = 1'b0; in_byte = ~b; in_is_cmd = ~c;
  endtask

  task automatic wait_strobe_low();
    for (int i = 0; i < 60 && strobe !== 1'b0; i++) @(negedge clk);
  endtask

  // drives the host side after strobe is low; returns on completion
  task automatic finish(input logic [W-1:0] b, input logic c, input int hd, input int dd);
    int k;
    wait_strobe_low();
    #1;
    chk("R4 strobe low", strobe, 0);
    chk("R4 data", bus_dout, b);
    chk("R4 tag", tag, c ? 0 : 1);
    chk("R3 grant low", grant_n, 0);
    chk("R3 oe after grant", t_oerise - t_gfall, 1);
    chk("R5 strobe after oe", t_sfall - t_oerise, 1);
    repeat (hd) @(negedge clk);
    chk("R6 strobe waits ack", strobe, 0);
    host_ack = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (strobe !== 1'b1 && k < 20);
    chk("R6 strobe rise latency", k, 3);
    repeat (dd) @(negedge clk);
    chk("R7 oe held", bus_oe, 1);
    chk("R7 no early sent", sent, 0);
    host_ack = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (bus_oe !== 1'b0 && k < 20);
    chk("R8 release latency", k, 3);
    chk("R8 tag low", tag, 0);
    chk("R8 strobe high", strobe, 1);
    chk("R8 grant still low", grant_n, 0);
    @(negedge clk);
    chk("R8 grant up", grant_n, 1);
    chk("R9 sent pulse", sent, 1);
    chk("R9 ready back", in_ready, 1);
    @(negedge clk);
    chk("R9 sent width", sent, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oe", bus_oe, 0);
    chk("R1 strobe", strobe, 1);
    chk("R1 tag", tag, 0);
    chk("R1 grant", grant_n, 1);
    chk("R1 sent", sent, 0);
    chk("R1 ready", in_ready, 1);

    // R2: request held high keeps the byte pending
    offer(8'hA5, 1'b0);
    repeat (30) @(negedge clk);
    chk("R2 grant", grant_n, 1);
    chk("R2 oe", bus_oe, 0);
    chk("R2 ready", in_ready, 0);
    rev_req_n = 1'b0;
    finish(8'hA5, 1'b0, 0, 0);

    // sweep every byte value with varied tag and host spacing
    for (int v = 0; v < 256; v++) begin
      offer(v[7:0], v[0] ^ v[7]);
      finish(v[7:0], v[0] ^ v[7], v % 3, (v / 4) % 3);
    end

    // R9: stray offer during a busy cycle
    offer(8'h3C, 1'b1);
    wait_strobe_low();
    in_valid = 1'b1; in_byte = 8'hFF; in_is_cmd = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    finish(8'h3C, 1'b1, 1, 1);
    repeat (20) @(negedge clk);
    chk("R9 no extra transfer", grant_n, 1);

    // R10: cancel while strobe is low
    offer(8'h5A, 1'b1);
    wait_strobe_low();
    @(negedge clk);
    rev_req_n = 1'b1;
    begin
      int k = 0;
      do begin @(negedge clk); k++; end while (bus_oe !== 1'b0 && k < 20);
      chk("R10 cancel release latency", k, 3);
    end
    chk("R10 strobe restored", strobe, 1);
    @(negedge clk);
    chk("R10 grant up", grant_n, 1);
    chk("R10 no sent", sent, 0);
    repeat (10) @(negedge clk);
    chk("R10 held pending", in_ready, 0);
    chk("R10 no regrant", grant_n, 1);
    rev_req_n = 1'b0;
    finish(8'h5A, 1'b1, 0, 2);

    // R10: cancel while waiting for host ack to drop
    offer(8'hC3, 1'b0);
    wait_strobe_low();
    host_ack = 1'b1;
    for (int i = 0; i < 20 && strobe !== 1'b1; i++) @(negedge clk);
    rev_req_n = 1'b1;
    for (int i = 0; i < 20 && grant_n !== 1'b1; i++) begin
      @(negedge clk);
      if (sent) chk("R10 no sent in hold cancel", 1, 0);
    end
    chk("R10 hold cancel grant up", grant_n, 1);
    chk("R10 hold cancel oe", bus_oe, 0);
    host_ack = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 hold cancel ready", in_ready, 0);
    rev_req_n = 1'b0;
    finish(8'hC3, 1'b0, 2, 0);

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule